// File: doc/BRIEF.md
# LED Shift-Chain Serialiser

This block is a register-mapped peripheral that feeds an external chain of 8-bit shift registers. LED drivers are the usual load. It shifts out up to three byte groups over a serial clock and a serial data line. It then pulses a store strobe once, so every parallel output of the chain changes on the same edge.

A transfer can start in two ways. Software can start one by setting a self-clearing go bit. A periodic timer can also refresh the chain by itself at one of four low rates, counted in bus-clock cycles.

Each of the eight lowest chain bits can be handed to a hardware status source instead of the CPU data register:
- a modem status pair on bits 0-1;
- a first PHY triple on bits 2-4;
- a second PHY triple on bits 5-7.

The bus is a plain single-cycle 32-bit write port with a combinational read port.

Top module: `stp_led_ctrl`

## Requirements
- R1: After reset, every register reads 0. The serial clock sits at 0, and serial data and store are 0.
- R2: The five registers sit at byte offsets 0x00 (control A), 0x04 (control B), 0x08 (data 0), 0x0C (data 1) and 0x10 (access). Each reads back what was last written, apart from control A bit 31.
- R3: A transfer shifts 8 x (index+1 of the highest set bit of control B [2:0]) bits of data 0. It goes MSB first, starting at the highest shifted bit.
- R4: Control A bit 26 picks the active serial clock edge. With 0 the clock idles low and data is taken on rising edges. With 1 it idles high and data is taken on falling edges. Serial data changes only while the clock is at its idle level.
- R5: After the last bit, store is high for exactly 2*SCLK_HALF bus cycles while the serial clock stays at its idle level.
- R6: Writing 1 to control A bit 31 starts a transfer. That bit reads 1 until the transfer has completed and then clears itself.
- R7: A go written during a transfer is held and served once the running transfer ends. Each transfer uses the data captured when it starts.
- R8: A set ownership bit replaces the data-0 bit with its hardware input. The ownership bits are control A [25:24] for modem bits 0-1, control A [29:27] for PHY1 bits 2-4, and control B [17:15] for PHY2 bits 5-7.
- R9: With control B bit 31 set, a transfer starts every CLK_HZ/f bus cycles. The frequency f comes from control B [24:23]: 00 = 2, 01 = 4, 10 = 8, 11 = 10.
- R10: A go issued with no group enabled causes no serial activity, and the go bit clears at once.
- R11: With no transfer pending, serial data and store stay 0 and the serial clock stays at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| dsl_led_i | input | 2 | Modem status for chain bits 0-1 |
| phy1_led_i | input | 3 | PHY1 status for chain bits 2-4 |
| phy2_led_i | input | 3 | PHY2 status for chain bits 5-7 |
| sclk_o | output | 1 | Serial shift clock |
| sdata_o | output | 1 | Serial data |
| store_o | output | 1 | Latch strobe to the chain |

## Verification
The bench builds the block with CLK_HZ = 4000 and SCLK_HALF = 2. These values shrink the refresh periods to 2000, 1000, 500 and 400 bus cycles, so every rate code can be timed over whole intervals within a short run. A 24-bit frame then takes about 100 cycles, which leaves room to queue a second go in the middle of a transfer. Frames are rebuilt from the captured edges in both clock polarities and compared with the ownership-merged data.

// File: rtl/stp_pkg.sv
// Shared constants and helpers for the LED shift-chain serialiser.
// Assumes the groups are equal in width and that group 0 holds the
// bits that may be owned by hardware sources.
package stp_pkg;
    localparam int GRP_CNT = 3;
    localparam int GRP_W   = 8;
    localparam int FRAME_W = GRP_CNT * GRP_W;
    localparam int NB_W    = $clog2(FRAME_W + 1);

    localparam logic [4:0] OFS_CTRL_A = 5'h00;
    localparam logic [4:0] OFS_CTRL_B = 5'h04;
    localparam logic [4:0] OFS_DATA0  = 5'h08;
    localparam logic [4:0] OFS_DATA1  = 5'h0C;
    localparam logic [4:0] OFS_ACCESS = 5'h10;

    typedef enum logic [1:0] {SH_IDLE, SH_SHIFT, SH_STORE} sh_state_t;

    // Number of bits to shift: set by the highest enabled group.
    function automatic logic [NB_W-1:0] frame_bits(input logic [GRP_CNT-1:0] en);
        logic [NB_W-1:0] n;
        n = '0;
        for (int g = 0; g < GRP_CNT; g++) begin
            if (en[g]) n = NB_W'((g + 1) * GRP_W);
        end
        return n;
    endfunction
endpackage

// File: rtl/stp_regs.sv
// Register file and software-request bookkeeping.
// Holds the control, data and access registers. It also tracks the
// self-clearing go bit as "waiting" (not yet launched) plus "in flight".
// Assumes single-cycle writes and a combinational read.
module stp_regs
    import stp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [4:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic                sw_take,
    input  logic                sw_run,
    input  logic                xfer_done,
    output logic                sw_wait,
    output logic                edge_fall,
    output logic [1:0]          dsl_own,
    output logic [2:0]          phy1_own,
    output logic [2:0]          phy2_own,
    output logic [GRP_CNT-1:0]  grp_en,
    output logic [1:0]          rate_sel,
    output logic                auto_en,
    output logic [FRAME_W-1:0]  cpu_data
);
    logic [30:0] ctrl_a_q;
    logic [31:0] ctrl_b_q, data0_q, data1_q, access_q;
    logic        sw_fly;
    logic        go_set;

    assign go_set = bus_wr && (bus_addr == OFS_CTRL_A) && bus_wdata[31];

    // Register storage, written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_a_q <= '0;
            ctrl_b_q <= '0;
            data0_q  <= '0;
            data1_q  <= '0;
            access_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_CTRL_A: ctrl_a_q <= bus_wdata[30:0];
                OFS_CTRL_B: ctrl_b_q <= bus_wdata;
                OFS_DATA0:  data0_q  <= bus_wdata;
                OFS_DATA1:  data1_q  <= bus_wdata;
                OFS_ACCESS: access_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Software request: waiting until launched, then in flight until done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_wait <= 1'b0;
            sw_fly  <= 1'b0;
        end else begin
            if (go_set)       sw_wait <= 1'b1;
            else if (sw_take) sw_wait <= 1'b0;
            if (sw_run)         sw_fly <= 1'b1;
            else if (xfer_done) sw_fly <= 1'b0;
        end
    end

    // Read multiplexer.
    always_comb begin
        case (bus_addr)
            OFS_CTRL_A: bus_rdata = {sw_wait | sw_fly, ctrl_a_q};
            OFS_CTRL_B: bus_rdata = ctrl_b_q;
            OFS_DATA0:  bus_rdata = data0_q;
            OFS_DATA1:  bus_rdata = data1_q;
            OFS_ACCESS: bus_rdata = access_q;
            default:    bus_rdata = '0;
        endcase
    end

    assign edge_fall = ctrl_a_q[26];
    assign dsl_own   = ctrl_a_q[25:24];
    assign phy1_own  = ctrl_a_q[29:27];
    assign phy2_own  = ctrl_b_q[17:15];
    assign grp_en    = ctrl_b_q[GRP_CNT-1:0];
    assign rate_sel  = ctrl_b_q[24:23];
    assign auto_en   = ctrl_b_q[31];
    assign cpu_data  = data0_q[FRAME_W-1:0];
endmodule

// File: rtl/stp_timer.sv
// Refresh timer for automatic mode.
// Emits a one-cycle tick every CLK_HZ/f bus cycles, with f taken from
// the rate code. Assumes CLK_HZ is at least 10.
module stp_timer #(
    parameter int CLK_HZ = 1_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] rate_sel,
    output logic       tick
);
    localparam int LIM_2  = CLK_HZ / 2;
    localparam int LIM_4  = CLK_HZ / 4;
    localparam int LIM_8  = CLK_HZ / 8;
    localparam int LIM_10 = CLK_HZ / 10;
    localparam int CNT_W  = $clog2(LIM_2 + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    // Last count value of the selected period.
    always_comb begin
        case (rate_sel)
            2'd0:    last = CNT_W'(LIM_2 - 1);
            2'd1:    last = CNT_W'(LIM_4 - 1);
            2'd2:    last = CNT_W'(LIM_8 - 1);
            default: last = CNT_W'(LIM_10 - 1);
        endcase
    end

    assign tick = en && (cnt >= last);

    // Free-running period counter, held at zero while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt <= '0;
        else if (cnt >= last) cnt <= '0;
        else cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/stp_shifter.sv
// Shift engine. It loads a frame on start and shifts nbits of it MSB
// first. Each bit lasts 2*SCLK_HALF cycles: the first half at the idle
// clock level, the second half at the active level. A store pulse one
// serial period long follows. Assumes nbits is nonzero on start.
module stp_shifter
    import stp_pkg::*;
#(
    parameter int SCLK_HALF = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    input  logic [NB_W-1:0]    nbits,
    input  logic               edge_fall,
    output logic               idle,
    output logic               done,
    output logic               sclk_o,
    output logic               sdata_o,
    output logic               store_o
);
    localparam int PER   = 2 * SCLK_HALF;
    localparam int CNT_W = (PER > 2) ? $clog2(PER) : 1;
    localparam int IDX_W = $clog2(FRAME_W);

    sh_state_t          state;
    logic [CNT_W-1:0]   cnt;
    logic [IDX_W-1:0]   idx;
    logic [FRAME_W-1:0] frame_q;
    logic               per_end;

    assign per_end = (cnt == CNT_W'(PER - 1));

    // Sequencer: idle, shift each bit, then hold the store strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SH_IDLE;
            cnt     <= '0;
            idx     <= '0;
            frame_q <= '0;
        end else begin
            case (state)
                SH_IDLE: if (start) begin
                    frame_q <= frame;
                    idx     <= IDX_W'(nbits - 1'b1);
                    cnt     <= '0;
                    state   <= SH_SHIFT;
                end
                SH_SHIFT: begin
                    cnt <= per_end ? '0 : cnt + 1'b1;
                    if (per_end) begin
                        if (idx == '0) state <= SH_STORE;
                        else           idx   <= idx - 1'b1;
                    end
                end
                SH_STORE: begin
                    cnt <= per_end ? '0 : cnt + 1'b1;
                    if (per_end) state <= SH_IDLE;
                end
                default: state <= SH_IDLE;
            endcase
        end
    end

    assign idle    = (state == SH_IDLE);
    assign done    = (state == SH_STORE) && per_end;
    assign store_o = (state == SH_STORE);
    assign sdata_o = (state == SH_SHIFT) ? frame_q[idx] : 1'b0;
    assign sclk_o  = ((state == SH_SHIFT) && (cnt >= CNT_W'(SCLK_HALF))) ? ~edge_fall : edge_fall;
endmodule

// File: rtl/stp_led_ctrl.sv
// Top of the LED shift-chain serialiser. Merges hardware-owned status
// bits into group 0 of the frame and arbitrates software and timer
// starts; software wins. A timer tick that lands while the engine is
// busy is dropped.
module stp_led_ctrl
    import stp_pkg::*;
#(
    parameter int CLK_HZ    = 1_000_000,
    parameter int SCLK_HALF = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [1:0]  dsl_led_i,
    input  logic [2:0]  phy1_led_i,
    input  logic [2:0]  phy2_led_i,
    output logic        sclk_o,
    output logic        sdata_o,
    output logic        store_o
);
    logic               sw_wait, sw_take, sw_run, xfer_done, sh_idle, sh_start;
    logic               edge_fall, auto_en, tick, busy;
    logic [1:0]         dsl_own, rate_sel;
    logic [2:0]         phy1_own, phy2_own;
    logic [GRP_CNT-1:0] grp_en;
    logic [FRAME_W-1:0] cpu_data, frame;
    logic [GRP_W-1:0]   own_mask, hw_bits, low_bits;
    logic [NB_W-1:0]    nbits;

    stp_regs regs_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sw_take(sw_take),
        .sw_run(sw_run), .xfer_done(xfer_done), .sw_wait(sw_wait),
        .edge_fall(edge_fall), .dsl_own(dsl_own), .phy1_own(phy1_own),
        .phy2_own(phy2_own), .grp_en(grp_en), .rate_sel(rate_sel),
        .auto_en(auto_en), .cpu_data(cpu_data)
    );

    stp_timer #(.CLK_HZ(CLK_HZ)) timer_i (
        .clk(clk), .rst_n(rst_n), .en(auto_en), .rate_sel(rate_sel), .tick(tick)
    );

    assign own_mask = {phy2_own, phy1_own, dsl_own};
    assign hw_bits  = {phy2_led_i, phy1_led_i, dsl_led_i};

    // Per-bit source select for the hardware-ownable group.
    for (genvar b = 0; b < GRP_W; b++) begin : g_own_mux
        assign low_bits[b] = own_mask[b] ? hw_bits[b] : cpu_data[b];
    end
    assign frame = {cpu_data[FRAME_W-1:GRP_W], low_bits};

    assign nbits    = frame_bits(grp_en);
    assign sw_take  = sh_idle && sw_wait;
    assign sw_run   = sw_take && (nbits != '0);
    assign sh_start = sh_idle && (sw_wait || tick) && (nbits != '0);
    assign busy     = !sh_idle;

    stp_shifter #(.SCLK_HALF(SCLK_HALF)) shifter_i (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .frame(frame),
        .nbits(nbits), .edge_fall(edge_fall), .idle(sh_idle),
        .done(xfer_done), .sclk_o(sclk_o), .sdata_o(sdata_o), .store_o(store_o)
    );
endmodule

// File: rtl/stp_led_ctrl_chk.sv
// Protocol checker for the serial outputs, bound to the top module.
module stp_led_ctrl_chk #(
    parameter int SCLK_HALF = 4
) (
    input logic clk,
    input logic rst_n,
    input logic sclk_o,
    input logic sdata_o,
    input logic store_o,
    input logic edge_fall,
    input logic busy
);
    localparam int PER = 2 * SCLK_HALF;
    int run_q;

    // Length of the current store pulse, in cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)       run_q <= 0;
        else if (store_o) run_q <= run_q + 1;
        else              run_q <= 0;
    end

    // R5
    store_idle_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_o |-> (sclk_o == edge_fall));

    // R5
    store_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(store_o) |-> (run_q == PER));

    // R4
    sdata_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata_o) |-> (sclk_o == edge_fall));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sdata_o && !store_o && (sclk_o == edge_fall)));
endmodule

bind stp_led_ctrl stp_led_ctrl_chk #(.SCLK_HALF(SCLK_HALF)) chk_i (
    .clk(clk), .rst_n(rst_n), .sclk_o(sclk_o), .sdata_o(sdata_o),
    .store_o(store_o), .edge_fall(edge_fall), .busy(busy)
);

// File: tb/stp_led_ctrl_tb_top.sv
module stp_led_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 4000;
    localparam int HALF       = 2;
    localparam int PER        = 2 * HALF;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [1:0]  dsl_i = '0;
    logic [2:0]  phy1_i = '0, phy2_i = '0;
    logic        sclk, sdata, store;

    always #(CLK_PERIOD/2) clk = ~clk;

    stp_led_ctrl #(.CLK_HZ(CLK_HZ), .SCLK_HALF(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dsl_led_i(dsl_i),
        .phy1_led_i(phy1_i), .phy2_led_i(phy2_i), .sclk_o(sclk),
        .sdata_o(sdata), .store_o(store)
    );

    int nchk = 0, nfail = 0, cyc = 0;
    logic edge_f = 1'b0, mon_on = 1'b0, prev_sclk = 1'b0, prev_store = 1'b0;
    logic [31:0] cap_val = '0;
    int cap_len = 0, run = 0, nfr = 0, ndone = 0;
    logic [31:0] frames[256];
    int flen[256];
    int rise_cyc[256];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    // Cycle counter and watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nfail++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            finish_run();
        end
    end

    // Behavioural receiver model: a chain fed by the serial outputs,
    // checked on every clock.
    always @(negedge clk) begin
        if (mon_on) begin
            if (!prev_store && store) begin
                if (nfr < 256) begin
                    frames[nfr] = cap_val; flen[nfr] = cap_len; rise_cyc[nfr] = cyc;
                end
                nfr++;
                cap_val = '0; cap_len = 0; run = 0;
            end
            if (store) begin
                run++;
                chk(sclk == edge_f, "R5 sclk idle during store", sclk, edge_f);
            end
            if (prev_store && !store) begin
                chk(run == PER, "R5 store length", run, PER);
                ndone++;
            end
            if (!store && prev_sclk != sclk && sclk == !edge_f) begin
                cap_val = {cap_val[30:0], sdata};
                cap_len++;
            end
            prev_sclk = sclk;
            prev_store = store;
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_done(input int target);
        int t = 0;
        while (ndone < target && t < 20000) begin
            @(negedge clk); t++;
        end
        chk(ndone >= target, "R6 transfer completes", ndone, target);
    endtask

    task automatic wait_frames(input int target);
        int t = 0;
        while (nfr < target && t < 20000) begin
            @(negedge clk); t++;
        end
        chk(nfr >= target, "R9 refresh occurs", nfr, target);
    endtask

    task automatic go_and_check(input logic [31:0] ctla, input logic [31:0] exp, input int len, input string req);
        int base;
        logic [31:0] r;
        base = ndone;
        wr(5'h00, ctla | 32'h8000_0000);
        rd(5'h00, r);
        chk(r[31] == 1'b1, "R6 go reads 1 while busy", r[31], 1);
        wait_done(base + 1);
        rd(5'h00, r);
        chk(r[31] == 1'b0, "R6 go self-clears", r[31], 0);
        chk(flen[nfr-1] == len, {req, " length"}, flen[nfr-1], len);
        chk(frames[nfr-1] == exp, {req, " data"}, frames[nfr-1], exp);
    endtask

    initial begin
        logic [31:0] r;
        logic [7:0] own, hw, exp8;
        int base, bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;
        // R1 reset state
        for (int i = 0; i < 5; i++) begin
            rd(5'(i * 4), r);
            chk(r == 0, "R1 register reset", r, 0);
        end
        chk(sclk == 0 && sdata == 0 && store == 0, "R1 outputs reset", {sclk, sdata, store}, 0);

        // R2 map and readback
        wr(5'h04, 32'h4003_8002); rd(5'h04, r); chk(r == 32'h4003_8002, "R2 ctrl B", r, 32'h4003_8002);
        wr(5'h08, 32'hDEAD_BEEF); rd(5'h08, r); chk(r == 32'hDEAD_BEEF, "R2 data 0", r, 32'hDEAD_BEEF);
        wr(5'h0C, 32'h1357_9BDF); rd(5'h0C, r); chk(r == 32'h1357_9BDF, "R2 data 1", r, 32'h1357_9BDF);
        wr(5'h10, 32'hCAFE_0001); rd(5'h10, r); chk(r == 32'hCAFE_0001, "R2 access", r, 32'hCAFE_0001);
        wr(5'h00, 32'h0300_0000); rd(5'h00, r); chk(r == 32'h0300_0000, "R2 ctrl A", r, 32'h0300_0000);
        wr(5'h00, 32'h0);

        // R3 frame length and order
        wr(5'h04, 32'h1); wr(5'h08, 32'h0000_00A5);
        go_and_check(32'h0, 32'hA5, 8, "R3 group0");
        wr(5'h04, 32'h3); wr(5'h08, 32'h1234_5678);
        go_and_check(32'h0, 32'h5678, 16, "R3 groups01");
        wr(5'h04, 32'h4);
        go_and_check(32'h0, 32'h34_5678, 24, "R3 group2 only");

        // R4 falling edge mode
        edge_f = 1'b1;
        wr(5'h00, 32'h0400_0000);
        @(negedge clk);
        chk(sclk == 1'b1, "R4 falling idle level", sclk, 1);
        wr(5'h04, 32'h1); wr(5'h08, 32'h0000_0096);
        go_and_check(32'h0400_0000, 32'h96, 8, "R4 falling");
        edge_f = 1'b0;
        wr(5'h00, 32'h0);
        @(negedge clk);
        chk(sclk == 1'b0, "R4 rising idle level", sclk, 0);

        // R8 hardware ownership
        dsl_i = 2'b11; phy1_i = 3'b101; phy2_i = 3'b110;
        wr(5'h08, 32'h0000_003C);
        wr(5'h04, 32'h0001_0001);
        own = {3'b010, 3'b111, 2'b01};
        hw  = {phy2_i, phy1_i, dsl_i};
        exp8 = (own & hw) | (~own & 8'h3C);
        go_and_check(32'h3900_0000, {24'h0, exp8}, 8, "R8 mixed ownership");
        wr(5'h04, 32'h0003_8001);
        own = {3'b111, 3'b000, 2'b10};
        exp8 = (own & hw) | (~own & 8'h3C);
        go_and_check(32'h0200_0000, {24'h0, exp8}, 8, "R8 phy2 and dsl");
        wr(5'h04, 32'h1);
        go_and_check(32'h0, 32'h3C, 8, "R8 no ownership");

        // R7 go during transfer is held; data captured at start
        wr(5'h04, 32'h7); wr(5'h08, 32'h00AA_AA55);
        base = ndone;
        wr(5'h00, 32'h8000_0000);
        repeat (20) @(negedge clk);
        wr(5'h08, 32'h0012_3456);
        wr(5'h00, 32'h8000_0000);
        wait_done(base + 1);
        rd(5'h00, r); chk(r[31] == 1'b1, "R7 held go still set", r[31], 1);
        chk(frames[nfr-1] == 32'hAA_AA55, "R7 first frame", frames[nfr-1], 32'hAA_AA55);
        wait_done(base + 2);
        chk(frames[nfr-1] == 32'h12_3456, "R7 second frame", frames[nfr-1], 32'h12_3456);
        rd(5'h00, r); chk(r[31] == 1'b0, "R7 go cleared after both", r[31], 0);

        // R10 no groups enabled
        wr(5'h04, 32'h0);
        base = nfr;
        wr(5'h00, 32'h8000_0000);
        repeat (2) @(negedge clk);
        rd(5'h00, r); chk(r[31] == 1'b0, "R10 go clears", r[31], 0);
        bad = 0;
        repeat (200) begin @(negedge clk); if (sdata || store || sclk) bad++; end
        chk(nfr == base && bad == 0, "R10 no activity", bad, 0);

        // R9 automatic refresh rates
        wr(5'h08, 32'h0000_0081);
        for (int rs = 0; rs < 4; rs++) begin
            int hz, p;
            hz = (rs == 0) ? 2 : (rs == 1) ? 4 : (rs == 2) ? 8 : 10;
            wr(5'h04, 32'h8000_0001 | (32'(rs) << 23));
            base = nfr;
            wait_frames(base + 3);
            p = rise_cyc[base + 2] - rise_cyc[base + 1];
            chk(p == CLK_HZ / hz, "R9 refresh interval", p, CLK_HZ / hz);
            chk(frames[base + 2] == 32'h81, "R9 refresh data", frames[base + 2], 32'h81);
        end

        // R11 quiet once automatic mode is off
        wr(5'h04, 32'h1);
        repeat (50) @(negedge clk);
        base = nfr; bad = 0;
        repeat (3000) begin @(negedge clk); if (sdata || store || sclk) bad++; end
        chk(nfr == base && bad == 0, "R11 idle quiet", bad, 0);

        finish_run();
    end
endmodule